// File: doc/BRIEF.md
# SDIO In-Band Card Interrupt Gate

This block is the host-side status and enable unit for the card interrupt that an SDIO device signals in-band on its DAT1 line. DAT1 is treated as an active-low level. It passes through a two-stage synchronizer and is sampled only while no data transfer owns the line. The sampled level is shown as the card-interrupt status bit. Two event bits sit in the same status word: command complete and data complete. Each has a matching enable bit. The block raises a host interrupt when any status bit and its enable bit are both set.

A card that keeps DAT1 low would otherwise interrupt the host on every cycle. To prevent this, the block clears the card enable by itself in the cycle after it takes a card interrupt. The enable stays cleared until software writes it again, which software does after it has read the pending data. Software reaches the block through a single-cycle write port. One select value writes the status word, where a 1 clears an event bit. The other select value loads the enable word. An encoded cause output reports the pending source with the highest priority. Command completion ranks first, then data completion, then the card.

If a software write sets the card enable in the same cycle that a card interrupt is taken, the automatic clear wins for that bit.

Top module: `sdio_cirq_gate`

## Requirements
- R1: After a synchronous reset, status_o, enable_o, irq_o and irq_src are all zero.
- R2: Status bit 0 (command complete) and bit 1 (data complete) are set by a high on cmd_done or data_done at a clock edge. Each is cleared by a write with wr_sel=0 that carries a 1 at its position. If a set and a clear fall on the same edge, the set wins.
- R3: Status bit 8 equals the inverse of dat1_n. It first shows a change of dat1_n on the third rising edge after the change. Writing 1 to bit 8 with wr_sel=0 has no effect.
- R4: While xfer_busy is high, status bit 8 holds its value whatever dat1_n does. At the first edge with xfer_busy low, bit 8 takes the synchronized level again.
- R5: A write with wr_sel=1 loads the enable word. Only bits 0, 1 and 8 are implemented; the other enable and status bits always read 0.
- R6: irq_o is a register. One edge after any status bit and its enable bit are both set, irq_o is high. Otherwise irq_o is low.
- R7: On the edge after card status and card enable are both set, the card enable (enable_o bit 8) clears and irq_o rises for one cycle. While DAT1 remains low, no further interrupt follows.
- R8: Writing the card enable again while DAT1 is still low produces exactly one more single-cycle irq_o pulse, after which the enable is cleared again.
- R9: irq_src is registered with the same timing as irq_o. It encodes the enabled pending source with the highest priority: 1 = command, 2 = data, 3 = card, 0 = none. Command ranks above data, and data ranks above card.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dat1_n | input | 1 | Asynchronous DAT1 line, low requests an interrupt |
| xfer_busy | input | 1 | High while a data transfer uses DAT1; sampling is frozen |
| cmd_done | input | 1 | Command-complete event, one cycle |
| data_done | input | 1 | Data-complete event, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = write-one-to-clear the status word, 1 = load the enable word |
| wr_data | input | REG_W | Write data |
| status_o | output | REG_W | Status word (bit 0 command, bit 1 data, bit 8 card) |
| enable_o | output | REG_W | Enable word, same bit layout |
| irq_o | output | 1 | Host interrupt request |
| irq_src | output | 2 | Encoded cause of irq_o |

## Verification
Each result appears a fixed number of edges after its stimulus. An event input or register write is visible in status_o or enable_o at the same edge that samples it. irq_o, irq_src and the automatic card-mask clear follow one edge later. A dat1_n change reaches status bit 8 at the third edge and irq_o at the fourth. The bench drives inputs a quarter period after a rising edge and checks a quarter period after the following edge. Each row of the vector table and each step of the directed tests therefore states the expected output for exactly that edge.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int CMD_BIT  = 0;
  localparam int DATA_BIT = 1;
  localparam int CARD_BIT = 8;
  localparam int N_EVT    = 2;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CMD  = 2'd1,
    SRC_DATA = 2'd2,
    SRC_CARD = 2'd3
  } src_e;

  function automatic int evt_pos(input int idx);
    return (idx == 0) ? CMD_BIT : DATA_BIT;
  endfunction
endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cirq_card_sample.sv
module cirq_card_sample (
  input  logic clk,
  input  logic rst,
  input  logic line_n_sync,
  input  logic hold,
  output logic card_lvl
);
  always_ff @(posedge clk) begin
    if (rst)        card_lvl <= 1'b0;
    else if (!hold) card_lvl <= ~line_n_sync;
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(hold)) |-> $stable(card_lvl));
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs
  import cirq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_set,
  input  logic             card_lvl,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] en_o
);
  localparam logic [REG_W-1:0] ONE       = REG_W'(1);
  localparam logic [REG_W-1:0] IMPL_MASK = (ONE << CMD_BIT) | (ONE << DATA_BIT) | (ONE << CARD_BIT);

  logic             w1c;
  logic [N_EVT-1:0] evt_q;
  logic [REG_W-1:0] en_q, en_nxt;

  assign w1c = wr_en && !wr_sel;

  for (genvar gi = 0; gi < N_EVT; gi++) begin : g_evt
    localparam int POS = evt_pos(gi);
    always_ff @(posedge clk) begin
      if (rst) evt_q[gi] <= 1'b0;
      else     evt_q[gi] <= evt_set[gi] | (evt_q[gi] & ~(w1c & wr_data[POS]));
    end
    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(evt_set[gi])) |-> stat_o[POS]);
  end

  always_comb begin
    en_nxt = en_q;
    if (wr_en && wr_sel) en_nxt = wr_data & IMPL_MASK;
    if (card_lvl && en_q[CARD_BIT]) en_nxt[CARD_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  always_comb begin
    stat_o = '0;
    for (int k = 0; k < N_EVT; k++) stat_o[evt_pos(k)] = evt_q[k];
    stat_o[CARD_BIT] = card_lvl;
  end

  assign en_o = en_q;

  // R5
  impl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((en_q & ~IMPL_MASK) == '0));
endmodule

// File: rtl/cirq_irq.sv
module cirq_irq
  import cirq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] en,
  output logic             irq_o,
  output src_e             src_o
);
  logic [REG_W-1:0] pend;
  src_e             src_nxt;

  assign pend = stat & en;

  always_comb begin
    if      (pend[CMD_BIT])  src_nxt = SRC_CMD;
    else if (pend[DATA_BIT]) src_nxt = SRC_DATA;
    else if (pend[CARD_BIT]) src_nxt = SRC_CARD;
    else                     src_nxt = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      src_o <= SRC_NONE;
    end else begin
      irq_o <= |pend;
      src_o <= src_nxt;
    end
  end

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == (|($past(stat) & $past(en)))));
  // R9
  src_valid_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (src_o != SRC_NONE));
endmodule

// File: rtl/sdio_cirq_gate.sv
module sdio_cirq_gate
  import cirq_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dat1_n,
  input  logic             xfer_busy,
  input  logic             cmd_done,
  input  logic             data_done,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] enable_o,
  output logic             irq_o,
  output logic [1:0]       irq_src
);
  logic             dat1_s;
  logic             card_lvl;
  logic [N_EVT-1:0] evt_set;
  src_e             src_q;

  assign evt_set = {data_done, cmd_done};

  cirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(dat1_n), .q(dat1_s)
  );

  cirq_card_sample u_card (
    .clk(clk), .rst(rst), .line_n_sync(dat1_s), .hold(xfer_busy), .card_lvl(card_lvl)
  );

  cirq_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .evt_set(evt_set), .card_lvl(card_lvl),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .stat_o(status_o), .en_o(enable_o)
  );

  cirq_irq #(.REG_W(REG_W)) u_irq (
    .clk(clk), .rst(rst), .stat(status_o), .en(enable_o),
    .irq_o(irq_o), .src_o(src_q)
  );

  assign irq_src = src_q;

  // R7
  auto_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status_o[CARD_BIT] && enable_o[CARD_BIT])) |-> !enable_o[CARD_BIT]);
  // R7
  card_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(status_o[CARD_BIT] && enable_o[CARD_BIT])) |-> irq_o);
endmodule

// File: tb/sim_sdio_cirq_gate.sv
module sim_sdio_cirq_gate;
  localparam int CLK_P = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst, dat1_n, xfer_busy, cmd_done, data_done, wr_en, wr_sel;
  logic [W-1:0] wr_data, status_o, enable_o;
  logic irq_o;
  logic [1:0] irq_src;
  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sdio_cirq_gate #(.REG_W(W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .dat1_n(dat1_n), .xfer_busy(xfer_busy),
    .cmd_done(cmd_done), .data_done(data_done), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status_o(status_o), .enable_o(enable_o),
    .irq_o(irq_o), .irq_src(irq_src)
  );

  typedef struct packed {
    logic        cmd;
    logic        dat;
    logic        we;
    logic        sel;
    logic [15:0] wd;
    logic [15:0] xstat;
    logic [15:0] xen;
    logic        xirq;
    logic [1:0]  xsrc;
  } vec_t;

  // R2 R5 R6 R9: event and enable paths with DAT1 idle
  localparam vec_t TBL [13] = '{
    '{1'b1,1'b0,1'b0,1'b0,16'h0000,16'h0001,16'h0000,1'b0,2'd0},
    '{1'b0,1'b0,1'b1,1'b1,16'h0003,16'h0001,16'h0003,1'b0,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0001,16'h0003,1'b1,2'd1},
    '{1'b0,1'b1,1'b0,1'b0,16'h0000,16'h0003,16'h0003,1'b1,2'd1},
    '{1'b0,1'b0,1'b1,1'b0,16'h0001,16'h0002,16'h0003,1'b1,2'd1},
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0002,16'h0003,1'b1,2'd2},
    '{1'b1,1'b0,1'b1,1'b0,16'h0002,16'h0001,16'h0003,1'b1,2'd2},
    '{1'b1,1'b0,1'b1,1'b0,16'h0001,16'h0001,16'h0003,1'b1,2'd1},
    '{1'b0,1'b0,1'b1,1'b1,16'h0000,16'h0001,16'h0000,1'b1,2'd1},
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0001,16'h0000,1'b0,2'd0},
    '{1'b0,1'b0,1'b1,1'b0,16'hFFFF,16'h0000,16'h0000,1'b0,2'd0},
    '{1'b0,1'b0,1'b1,1'b1,16'hFFFF,16'h0000,16'h0103,1'b0,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,16'h0000,16'h0000,16'h0103,1'b0,2'd0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle_inputs();
    cmd_done = 0; data_done = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst = 1; dat1_n = 1; xfer_busy = 0;
    idle_inputs();
    repeat (3) step();
    rst = 0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    idle_inputs();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1", "status", status_o, 0);
    chk("R1", "enable", enable_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "src", irq_src, 0);

    foreach (TBL[i]) begin
      cmd_done = TBL[i].cmd; data_done = TBL[i].dat;
      wr_en = TBL[i].we; wr_sel = TBL[i].sel; wr_data = TBL[i].wd;
      step();
      idle_inputs();
      chk("R2", $sformatf("row%0d status", i), status_o, TBL[i].xstat);
      chk("R5", $sformatf("row%0d enable", i), enable_o, TBL[i].xen);
      chk("R6", $sformatf("row%0d irq", i), irq_o, TBL[i].xirq);
      chk("R9", $sformatf("row%0d src", i), irq_src, TBL[i].xsrc);
    end

    // R3 R7 R8: card interrupt latency, auto-mask, re-enable
    do_reset();
    wr(1, 16'h0100);
    chk("R5", "card enable", enable_o, 16'h0100);
    dat1_n = 0;
    step(); chk("R3", "edge1 status", status_o, 0);
    step(); chk("R3", "edge2 status", status_o, 0);
    step(); chk("R3", "edge3 status", status_o, 16'h0100);
    chk("R6", "edge3 irq", irq_o, 0);
    step(); chk("R7", "taken irq", irq_o, 1);
    chk("R7", "taken src", irq_src, 3);
    chk("R7", "taken enable", enable_o, 0);
    step(); chk("R7", "pulse end", irq_o, 0);
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R7", "no storm irq", irq_o, 0);
      chk("R7", "line held status", status_o, 16'h0100);
    end
    wr(0, 16'h0100);
    chk("R3", "w1c card no effect", status_o, 16'h0100);
    wr(1, 16'h0100);
    chk("R8", "re-enable", enable_o, 16'h0100);
    chk("R8", "re-enable irq", irq_o, 0);
    step(); chk("R8", "second pulse", irq_o, 1);
    chk("R8", "second mask", enable_o, 0);
    step(); chk("R8", "second end", irq_o, 0);
    dat1_n = 1;
    step(); step(); chk("R3", "release edge2", status_o, 16'h0100);
    step(); chk("R3", "release edge3", status_o, 0);
    wr(1, 16'h0100);
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R6", "idle line irq", irq_o, 0);
    end
    chk("R7", "enable kept on idle line", enable_o, 16'h0100);

    // R4: sampling frozen during transfers
    xfer_busy = 1; dat1_n = 0;
    repeat (6) step();
    chk("R4", "busy low line status", status_o, 0);
    chk("R4", "busy low line irq", irq_o, 0);
    dat1_n = 1;
    repeat (4) step();
    xfer_busy = 0;
    step(); chk("R4", "glitch hidden", status_o, 0);
    dat1_n = 0;
    repeat (3) step();
    chk("R4", "set before busy", status_o, 16'h0100);
    step(); step();
    xfer_busy = 1; dat1_n = 1;
    repeat (5) step();
    chk("R4", "held through busy", status_o, 16'h0100);
    xfer_busy = 0;
    step(); chk("R4", "resample after busy", status_o, 0);

    // R9: priority among all three sources
    do_reset();
    dat1_n = 0;
    repeat (3) step();
    chk("R3", "masked card status", status_o, 16'h0100);
    chk("R6", "masked card irq", irq_o, 0);
    cmd_done = 1; data_done = 1; wr_en = 1; wr_sel = 1; wr_data = 16'h0103;
    step(); idle_inputs();
    chk("R2", "both events", status_o, 16'h0103);
    step(); chk("R9", "cmd first", irq_src, 1);
    chk("R7", "card masked with others", enable_o, 16'h0003);
    wr(0, 16'h0001);
    chk("R2", "clear cmd", status_o, 16'h0102);
    chk("R9", "cmd still reported", irq_src, 1);
    step(); chk("R9", "data next", irq_src, 2);
    wr(0, 16'h0002);
    chk("R2", "clear data", status_o, 16'h0100);
    step(); chk("R9", "none pending", irq_src, 0);
    chk("R6", "none irq", irq_o, 0);
    wr(1, 16'h0103);
    chk("R6", "enable write irq", irq_o, 0);
    step(); chk("R9", "card last", irq_src, 3);
    chk("R7", "card re-masked", enable_o, 16'h0003);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule